// File: doc/BRIEF.md
# Light-Level Threshold Comparator

This block watches one of four light-channel period counts and drives a single interrupt line from it. A 2-bit select picks the channel. Two magnitude comparisons run side by side, one against a low threshold and one against a high threshold, and each has its own polarity bit. A configuration word from the register file chooses how the two polarised comparisons are combined. The choices are: no output, low comparison only, high comparison only, a window (AND of both), or a hysteresis latch. A final inversion bit is applied last.

The stored decision changes only on a clock edge where the selected channel presents a fresh count and does not flag that count as overflowed. Thresholds, select and configuration come in as plain parallel inputs that the register file holds. The block keeps one bit of state, the raw decision before inversion, and that bit also serves as the hysteresis memory.

Top module: `light_level_cmp`

## Requirements
- R1: While rst_n is low, and until the first accepted sample after reset, the stored decision is 0, so irq_o equals cmp_cfg bit 4.
- R2: cmp_cfg bit map: bit 0 enables the low comparison, bit 1 is its polarity, bit 2 enables the high comparison, bit 3 is its polarity, bit 4 inverts the output, and bit 5 selects hysteresis. The low hit is bit1 XOR (count < th_lo) and the high hit is bit3 XOR (count < th_hi).
- R3: With both enables at 0, an accepted sample sets the decision to 0.
- R4: With only the low enable set, an accepted sample sets the decision to the low hit.
- R5: With only the high enable set, an accepted sample sets the decision to the high hit.
- R6: With both enables set and bit 5 clear, an accepted sample sets the decision to the AND of the low hit and the high hit.
- R7: With both enables set and bit 5 set, an accepted sample does one of three things. If the low hit is 0, the decision is cleared to 0, and this takes priority. Otherwise, if the high hit is 0, the decision is set to 1. If both hits are 1, the decision keeps its value.
- R8: ch_sel value i (0 = Y, 1 = R, 2 = G, 3 = B) compares chan_cnt bits [i*27 +: 27] and uses chan_stb bit i and chan_ovf bit i.
- R9: A sample is accepted at a rising clock edge when chan_stb[ch_sel] is 1 and chan_ovf[ch_sel] is 0, and the new decision shows on irq_o after that edge. A strobe on a channel that is not selected, or a sample flagged as overflowed, leaves the decision unchanged.
- R10: irq_o is the decision XOR cmp_cfg bit 4. A change of bit 4 reaches irq_o without waiting for a sample.
- R11: With the register-file reset settings (cmp_cfg = 0x03, th_lo = 8, ch_sel = 0), irq_o goes high after a Y sample of 8 or more and goes low after a Y sample below 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_cnt | input | NUM_CH*CNT_W (108) | Packed channel counts, channel i at bits [i*CNT_W +: CNT_W] |
| chan_stb | input | NUM_CH (4) | New-count strobe per channel |
| chan_ovf | input | NUM_CH (4) | Overflow flag per channel, qualifies the strobe |
| ch_sel | input | 2 | Channel to compare |
| cmp_cfg | input | 6 | Enables, polarities, output inversion, hysteresis |
| th_lo | input | CNT_W (27) | Low threshold |
| th_hi | input | CNT_W (27) | High threshold |
| irq_o | output | 1 | Interrupt output |

## Verification
One register sits between an accepted sample and the decision. The bench therefore drives each strobe for one cycle, starting at a falling edge, and compares irq_o at the next falling edge, after the capturing rising edge. The effect of the inversion bit is combinational, so it is sampled a time step after the bit changes, with no clock edge in between. After rst_n rises, the internal synchroniser takes two edges. The bench idles four cycles before the first sample, and the bound checks wait the same two edges before they judge any sample.

// File: rtl/lvc_pkg.sv
package lvc_pkg;

  typedef struct packed {
    logic hyst;
    logic out_inv;
    logic pol_hi;
    logic en_hi;
    logic pol_lo;
    logic en_lo;
  } cmp_cfg_t;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_LOW,
    MODE_HIGH,
    MODE_WINDOW,
    MODE_HYST
  } cmp_mode_e;

  function automatic cmp_mode_e mode_of(cmp_cfg_t c);
    cmp_mode_e m;
    case ({c.en_hi, c.en_lo})
      2'b00:   m = MODE_OFF;
      2'b01:   m = MODE_LOW;
      2'b10:   m = MODE_HIGH;
      default: m = c.hyst ? MODE_HYST : MODE_WINDOW;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lvc_chan_pick.sv
module lvc_chan_pick #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 27,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH*CNT_W-1:0] chan_cnt,
  input  logic [NUM_CH-1:0]       chan_stb,
  input  logic [NUM_CH-1:0]       chan_ovf,
  input  logic [SEL_W-1:0]        sel,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    take_o
);

  logic [CNT_W-1:0] cnt_arr [NUM_CH];
  logic [NUM_CH-1:0] good;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign cnt_arr[g] = chan_cnt[g*CNT_W +: CNT_W];
    assign good[g]    = chan_stb[g] & ~chan_ovf[g];
  end

  always_comb begin
    cnt_o  = cnt_arr[sel];
    take_o = good[sel];
  end

endmodule

// File: rtl/lvc_thr_cmp.sv
module lvc_thr_cmp #(
  parameter int CNT_W = 27
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             pol,
  output logic             hit
);

  logic below;

  always_comb begin
    below = (cnt < thr);
    hit   = pol ^ below;
  end

endmodule

// File: rtl/lvc_decide.sv
module lvc_decide
  import lvc_pkg::*;
(
  input  cmp_mode_e mode,
  input  logic      lo_hit,
  input  logic      hi_hit,
  input  logic      state_q,
  output logic      state_d
);

  always_comb begin
    case (mode)
      MODE_OFF:    state_d = 1'b0;
      MODE_LOW:    state_d = lo_hit;
      MODE_HIGH:   state_d = hi_hit;
      MODE_WINDOW: state_d = lo_hit & hi_hit;
      MODE_HYST: begin
        if (!lo_hit)      state_d = 1'b0;
        else if (!hi_hit) state_d = 1'b1;
        else              state_d = state_q;
      end
      default:     state_d = 1'b0;
    endcase
  end

endmodule

// File: rtl/light_level_cmp.sv
module light_level_cmp
  import lvc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 27
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH*CNT_W-1:0]       chan_cnt,
  input  logic [NUM_CH-1:0]             chan_stb,
  input  logic [NUM_CH-1:0]             chan_ovf,
  input  logic [$clog2(NUM_CH)-1:0]     ch_sel,
  input  logic [5:0]                    cmp_cfg,
  input  logic [CNT_W-1:0]              th_lo,
  input  logic [CNT_W-1:0]              th_hi,
  output logic                          irq_o
);

  localparam int RST_STAGES = 2;

  cmp_cfg_t         cfg;
  cmp_mode_e        mode;
  logic [CNT_W-1:0] cnt_sel;
  logic             take;
  logic             lo_hit;
  logic             hi_hit;
  logic             state_q;
  logic             state_d;
  logic [RST_STAGES-1:0] rst_sync_q;
  logic             rst_int_n;

  // reset: asserts at once, leaves after RST_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  always_comb begin
    cfg  = cmp_cfg_t'(cmp_cfg);
    mode = mode_of(cfg);
  end

  lvc_chan_pick #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_pick (
    .chan_cnt (chan_cnt),
    .chan_stb (chan_stb),
    .chan_ovf (chan_ovf),
    .sel      (ch_sel),
    .cnt_o    (cnt_sel),
    .take_o   (take)
  );

  lvc_thr_cmp #(.CNT_W(CNT_W)) u_cmp_lo (
    .cnt (cnt_sel),
    .thr (th_lo),
    .pol (cfg.pol_lo),
    .hit (lo_hit)
  );

  lvc_thr_cmp #(.CNT_W(CNT_W)) u_cmp_hi (
    .cnt (cnt_sel),
    .thr (th_hi),
    .pol (cfg.pol_hi),
    .hit (hi_hit)
  );

  lvc_decide u_decide (
    .mode    (mode),
    .lo_hit  (lo_hit),
    .hi_hit  (hi_hit),
    .state_q (state_q),
    .state_d (state_d)
  );

  // decision bit, doubles as hysteresis memory (R1, R9)
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  state_q <= 1'b0;
    else if (take)   state_q <= state_d;
  end

  assign irq_o = state_q ^ cfg.out_inv;

endmodule

// File: rtl/lvc_checker.sv
module lvc_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 27
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CH*CNT_W-1:0]   chan_cnt,
  input logic [NUM_CH-1:0]         chan_stb,
  input logic [NUM_CH-1:0]         chan_ovf,
  input logic [$clog2(NUM_CH)-1:0] ch_sel,
  input logic [5:0]                cmp_cfg,
  input logic [CNT_W-1:0]          th_lo,
  input logic [CNT_W-1:0]          th_hi,
  input logic                      irq_o
);

  logic [1:0]       up_cnt;
  logic             live;
  logic [CNT_W-1:0] sel_cnt;
  logic             acc;
  logic             lo_h;
  logic             hi_h;
  logic             raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  always_comb begin
    live    = (up_cnt >= 2'd2);
    sel_cnt = chan_cnt[int'(ch_sel)*CNT_W +: CNT_W];
    acc     = chan_stb[ch_sel] & ~chan_ovf[ch_sel];
    lo_h    = cmp_cfg[1] ^ (sel_cnt < th_lo);
    hi_h    = cmp_cfg[3] ^ (sel_cnt < th_hi);
    raw     = irq_o ^ cmp_cfg[4];
  end

  a_r9_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !acc) |=> $stable(raw));

  a_r3_off: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc && !cmp_cfg[0] && !cmp_cfg[2]) |=> !raw);

  a_r4_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc && cmp_cfg[0] && !cmp_cfg[2]) |=> (raw == $past(lo_h)));

  a_r5_high_only: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc && !cmp_cfg[0] && cmp_cfg[2]) |=> (raw == $past(hi_h)));

  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc && cmp_cfg[0] && cmp_cfg[2] && !cmp_cfg[5]) |=> (raw == $past(lo_h && hi_h)));

  a_r7_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc && cmp_cfg[0] && cmp_cfg[2] && cmp_cfg[5] && lo_h && hi_h) |=> $stable(raw));

  a_r7_hyst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc && cmp_cfg[0] && cmp_cfg[2] && cmp_cfg[5] && !lo_h) |=> !raw);

endmodule

bind light_level_cmp lvc_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_cnt (chan_cnt),
  .chan_stb (chan_stb),
  .chan_ovf (chan_ovf),
  .ch_sel   (ch_sel),
  .cmp_cfg  (cmp_cfg),
  .th_lo    (th_lo),
  .th_hi    (th_hi),
  .irq_o    (irq_o)
);

// File: tb/light_level_cmp_test.sv
`timescale 1ns/1ps
module light_level_cmp_test;

  localparam int NCH = 4;
  localparam int CW  = 27;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH*CW-1:0] chan_cnt;
  logic [NCH-1:0]    chan_stb;
  logic [NCH-1:0]    chan_ovf;
  logic [1:0]        ch_sel;
  logic [5:0]        cmp_cfg;
  logic [CW-1:0]     th_lo;
  logic [CW-1:0]     th_hi;
  logic              irq_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic exp_state;

  always #5 clk = ~clk;

  light_level_cmp #(.NUM_CH(NCH), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt), .chan_stb(chan_stb),
    .chan_ovf(chan_ovf), .ch_sel(ch_sel), .cmp_cfg(cmp_cfg),
    .th_lo(th_lo), .th_hi(th_hi), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%b expected %b (cfg=%h sel=%0d)", tag, got, exp, cmp_cfg, ch_sel);
    end
  endtask

  function automatic logic model_next(input logic [5:0] c, input logic [CW-1:0] v,
                                      input logic [CW-1:0] lo, input logic [CW-1:0] hi,
                                      input logic prev);
    logic lh, hh, r;
    lh = c[1] ^ (v < lo);
    hh = c[3] ^ (v < hi);
    case ({c[2], c[0]})
      2'b00: r = 1'b0;
      2'b01: r = lh;
      2'b10: r = hh;
      default: begin
        if (!c[5])   r = lh & hh;
        else if (!lh) r = 1'b0;
        else if (!hh) r = 1'b1;
        else          r = prev;
      end
    endcase
    return r;
  endfunction

  // one-cycle strobe on channel ch; result is due at the following falling edge
  task automatic put_sample(input int ch, input logic [CW-1:0] val, input logic ovf);
    @(negedge clk);
    chan_cnt[ch*CW +: CW] = val;
    chan_stb = '0;
    chan_ovf = '0;
    chan_stb[ch] = 1'b1;
    chan_ovf[ch] = ovf;
    if (ch == int'(ch_sel) && !ovf)
      exp_state = model_next(cmp_cfg, val, th_lo, th_hi, exp_state);
    @(negedge clk);
    chan_stb = '0;
    chan_ovf = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, irq_o=%b expected completion", irq_o);
      summary();
    end
  end

  initial begin
    int seq [12] = '{0, 7, 12, 7, 3, 7, 15, 15, 2, 11, 5, 4};
    string tag;
    rst_n    = 1'b0;
    chan_cnt = '0;
    chan_stb = '0;
    chan_ovf = '0;
    ch_sel   = 2'd0;
    cmp_cfg  = 6'h03;
    th_lo    = 27'd8;
    th_hi    = 27'd0;
    exp_state = 1'b0;

    // R1: reset state, with and without inversion
    repeat (3) @(negedge clk);
    chk("R1 reset", irq_o, 1'b0);
    cmp_cfg = 6'h13;
    #1 chk("R1 reset inverted", irq_o, 1'b1);
    cmp_cfg = 6'h03;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", irq_o, 1'b0);

    // R11: register-file reset settings on Y
    put_sample(0, 27'd9, 1'b0);          chk("R11 count 9", irq_o, 1'b1);
    put_sample(0, 27'd7, 1'b0);          chk("R11 count 7", irq_o, 1'b0);
    put_sample(0, 27'd8, 1'b0);          chk("R11 count 8", irq_o, 1'b1);
    put_sample(0, 27'd0, 1'b0);          chk("R11 count 0", irq_o, 1'b0);
    put_sample(0, 27'h7FFFFFF, 1'b0);    chk("R11 count max", irq_o, 1'b1);

    // R2-R6, R10: every enable/polarity/inversion combination, non-hysteresis
    th_lo = 27'd5;
    th_hi = 27'd10;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      cmp_cfg = 6'(c);
      ch_sel  = 2'(c % 4);
      #1 chk("R10 inversion applied", irq_o, exp_state ^ cmp_cfg[4]);
      case ({cmp_cfg[2], cmp_cfg[0]})
        2'b00:   tag = "R3 off";
        2'b01:   tag = "R4 low only";
        2'b10:   tag = "R5 high only";
        default: tag = "R6 window";
      endcase
      for (int v = 0; v < 15; v++) begin
        put_sample(c % 4, CW'(v), 1'b0);
        chk({tag, " R2"}, irq_o, exp_state ^ cmp_cfg[4]);
      end
    end

    // R7: hysteresis walk for each polarity pair and inversion
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      ch_sel  = 2'd1;
      cmp_cfg = {1'b1, 1'(p >> 2), 1'(p >> 1), 1'b1, 1'(p), 1'b1};
      for (int k = 0; k < 12; k++) begin
        put_sample(1, CW'(seq[k]), 1'b0);
        chk("R7 hysteresis", irq_o, exp_state ^ cmp_cfg[4]);
      end
    end

    // R8, R9: channel select and ignored strobes on other channels
    @(negedge clk);
    cmp_cfg = 6'h01;
    th_lo   = 27'd5;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      ch_sel = 2'(s);
      put_sample(s, 27'd9, 1'b0);
      chk("R8 selected high count", irq_o, 1'b0);
      for (int o = 0; o < 4; o++) begin
        if (o != s) begin
          put_sample(o, 27'd2, 1'b0);
          chk("R9 other channel ignored", irq_o, 1'b0);
        end
      end
      put_sample(s, 27'd2, 1'b0);
      chk("R8 selected low count", irq_o, 1'b1);
    end

    // R9: overflowed sample ignored
    @(negedge clk);
    ch_sel = 2'd0;
    put_sample(0, 27'd2, 1'b0);  chk("R9 set before overflow", irq_o, 1'b1);
    put_sample(0, 27'd9, 1'b1);  chk("R9 overflow ignored", irq_o, 1'b1);
    put_sample(0, 27'd9, 1'b0);  chk("R9 clean sample taken", irq_o, 1'b0);

    // R10: inversion without any sample
    @(negedge clk);
    cmp_cfg[4] = 1'b1;
    #1 chk("R10 invert high", irq_o, 1'b1);
    @(negedge clk);
    cmp_cfg[4] = 1'b0;
    #1 chk("R10 invert low", irq_o, 1'b0);

    // R1: reset clears a stored 1
    put_sample(0, 27'd2, 1'b0);  chk("R1 stored one", irq_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async clear", irq_o, 1'b0);
    exp_state = 1'b0;

    done = 1;
    summary();
  end

endmodule